// File: doc/BRIEF.md
# Synchronized Power-Down Clock Gater

This block sits between a bank of free-running clock sources and the pins that fan them out. It stops every output when an active-low power-down pin is asserted. Each output can also be switched off on its own through a static enable vector. The power-down pin is asynchronous. It first passes through a multi-stage synchronizer clocked by the fastest source, the CPU clock. After that it must hold the same level on consecutive CPU rising edges before the block changes state, so a short glitch on the pin never stops the clocks.

Each output has its own gating cell. The cell takes a new enable value only while its clock is low. An output that is stopped while it is high therefore finishes its high phase and then stays low. An output that is restarted produces its first pulse on its next rising edge. A PLL-off flag follows the recognized power-down state directly, with no extra register, so the analog side can shut its loops down.

Enable changes are meant for power-on configuration. Because every cell only opens during its own low phase, a change at an arbitrary time still cannot cut a pulse short.

Top module: `pdn_clk_gater`

## Requirements
- R1: While reset is high and after it is released with the pin high, `pll_off` is 0. Every output whose `clk_en` bit is 1 toggles.
- R2: A low level on `pwrdn_n` that the synchronizer samples on only one CPU rising edge does not cause power-down. `pll_off` stays 0 and the outputs keep toggling.
- R3: After `pwrdn_n` falls between CPU edges, `pll_off` is still 0 after the third following CPU rising edge. It becomes 1 after the fourth: two synchronizer stages, then two consecutive low samples.
- R4: `pll_off` is 1 exactly while power-down is recognized.
- R5: While power-down is recognized, every output stays low and produces no rising edge, whatever its enable bit is.
- R6: Every high pulse on every output lasts a full half period of its source clock. This holds across power-down entry and exit and across enable changes at any time.
- R7: An output whose `clk_en` bit is 0 (bit i controls `clk_out[i]`) stays low, and the outputs that are still enabled keep toggling.
- R8: Setting a `clk_en` bit back to 1 restarts that output at a later rising edge of its source.
- R9: After `pwrdn_n` rises, `pll_off` is still 1 after the third following CPU rising edge and becomes 0 after the fourth. Enabled outputs then resume, and disabled outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | NUM_CLK | Free-running clock sources; bit CPU_IDX (0) is the CPU clock used for synchronization |
| rst | input | 1 | Synchronous active-high reset in the CPU clock domain |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| clk_en | input | NUM_CLK | Per-output enable, 1 = output runs |
| clk_out | output | NUM_CLK | Gated clock outputs |
| pll_off | output | 1 | High while power-down is recognized |

## Verification
The delicate coincidence is power-down release landing on the same CPU edge as a static disable. The bench writes a new enable vector while the block is powered down and then raises the pin. The single gate update at the fourth CPU edge must then open some outputs and keep others closed. A scoreboard window after the release judges this by which outputs produce rising edges. A second coincidence comes from changing the enables at an offset that falls inside the CPU clock's high phase. A pulse-width monitor on every output must then see only full half-period pulses.

// File: rtl/pdg_pkg.sv
`timescale 1ns/1ps
package pdg_pkg;

    // width of the consecutive-sample counter in the qualifier
    localparam int unsigned QCNT_W = 4;

    typedef enum logic {
        PD_RUN  = 1'b0,
        PD_DOWN = 1'b1
    } pd_state_e;

    typedef struct packed {
        pd_state_e            state;
        logic [QCNT_W-1:0]    run;
    } qual_t;

    // synchronized pin level that argues for leaving the given state
    function automatic logic leave_level(pd_state_e s);
        return (s == PD_RUN) ? 1'b0 : 1'b1;
    endfunction

    function automatic pd_state_e flip_state(pd_state_e s);
        return (s == PD_RUN) ? PD_DOWN : PD_RUN;
    endfunction

endpackage

// File: rtl/pdg_sync.sv
`timescale 1ns/1ps
module pdg_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_LVL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pdg_qual.sv
`timescale 1ns/1ps
module pdg_qual
    import pdg_pkg::*;
#(
    parameter int unsigned QUAL_EDGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_in,
    output pd_state_e state
);

    localparam logic [QCNT_W-1:0] LAST = QCNT_W'(QUAL_EDGES - 1);

    qual_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '{state: PD_RUN, run: '0};
        end else if (lvl_in == leave_level(r.state)) begin
            if (r.run == LAST) begin
                r.state <= flip_state(r.state);
                r.run   <= '0;
            end else begin
                r.run <= r.run + 1'b1;
            end
        end else begin
            r.run <= '0;
        end
    end

    assign state = r.state;

    generate
        if (QUAL_EDGES >= 2) begin : g_two
            // R2
            qual_two_seen_chk: assert property (@(posedge clk) disable iff (rst)
                (r.state != $past(r.state)) |->
                    (($past(lvl_in) != logic'(r.state)) && ($past(lvl_in, 2) != logic'(r.state))));
        end
    endgenerate

    // R3
    qual_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        r.run <= LAST);

endmodule

// File: rtl/pdg_gate.sv
`timescale 1ns/1ps
module pdg_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);

    logic en_q;

    // transparent only during the low phase of the clock
    always_latch begin
        if (!clk_in) begin
            en_q <= en;
        end
    end

    assign clk_out = clk_in & en_q;

    always @(en_q) begin
        // R6
        gate_hold_chk: assert (clk_in !== 1'b1)
            else $error("gate enable changed during high phase");
    end

endmodule

// File: rtl/pdn_clk_gater.sv
`timescale 1ns/1ps
module pdn_clk_gater
    import pdg_pkg::*;
#(
    parameter int unsigned NUM_CLK     = 4,
    parameter int unsigned CPU_IDX     = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_EDGES  = 2
) (
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic               rst,
    input  logic               pwrdn_n,
    input  logic [NUM_CLK-1:0] clk_en,
    output logic [NUM_CLK-1:0] clk_out,
    output logic               pll_off
);

    logic               cpu_clk;
    logic               pin_sync;
    pd_state_e          pd_state;
    logic [NUM_CLK-1:0] gate_en;

    assign cpu_clk = clk_src[CPU_IDX];

    pdg_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_LVL (1'b1)
    ) u_sync (
        .clk      (cpu_clk),
        .rst      (rst),
        .async_in (pwrdn_n),
        .sync_out (pin_sync)
    );

    pdg_qual #(
        .QUAL_EDGES (QUAL_EDGES)
    ) u_qual (
        .clk    (cpu_clk),
        .rst    (rst),
        .lvl_in (pin_sync),
        .state  (pd_state)
    );

    assign pll_off = (pd_state == PD_DOWN);
    assign gate_en = pll_off ? '0 : clk_en;

    generate
        for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_gate
            pdg_gate u_gate (
                .clk_in  (clk_src[gi]),
                .en      (gate_en[gi]),
                .clk_out (clk_out[gi])
            );
        end
    endgenerate

    // R3
    pd_entry_needs_low_chk: assert property (@(posedge cpu_clk) disable iff (rst)
        $rose(pll_off) |-> !$past(pin_sync));

    // R9
    pd_exit_needs_high_chk: assert property (@(posedge cpu_clk) disable iff (rst)
        $fell(pll_off) |-> $past(pin_sync));

    // R5
    pd_cpu_out_low_chk: assert property (@(negedge cpu_clk) disable iff (rst)
        (pll_off && $past(pll_off)) |-> (clk_out[CPU_IDX] == 1'b0));

endmodule

// File: tb/pdn_clk_gater_bench.sv
`timescale 1ns/1ps
module pdn_clk_gater_bench;

    localparam int N = 4;

    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic [N-1:0] clk_src;
    logic         rst     = 1'b1;
    logic         pwrdn_n = 1'b1;
    logic [N-1:0] clk_en  = '1;
    logic [N-1:0] clk_out;
    logic         pll_off;

    assign clk_src = {c3, c2, c1, c0};

    pdn_clk_gater u_pdn_clk_gater (
        .clk_src (clk_src),
        .rst     (rst),
        .pwrdn_n (pwrdn_n),
        .clk_en  (clk_en),
        .clk_out (clk_out),
        .pll_off (pll_off)
    );

    // 200 MHz CPU clock; the others start 1 ns late so no edges coincide
    initial forever #2.5 c0 = ~c0;
    initial begin #1; forever #5.0  c1 = ~c1; end
    initial begin #1; forever #7.5  c2 = ~c2; end
    initial begin #1; forever #15.0 c3 = ~c3; end

    int errs   = 0;
    int checks = 0;
    bit done   = 0;
    bit arm    = 0;

    function automatic real half_of(int i);
        case (i)
            0: return 2.5;
            1: return 5.0;
            2: return 7.5;
            default: return 15.0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // pulse-width monitor (R6) and rising-edge counters
    int  rises  [N];
    real t_rise [N];
    initial for (int i = 0; i < N; i++) begin rises[i] = 0; t_rise[i] = -1.0; end

    for (genvar g = 0; g < N; g++) begin : g_mon
        always @(posedge clk_out[g]) begin
            rises[g]++;
            if (arm) t_rise[g] = $realtime;
        end
        always @(negedge clk_out[g]) begin
            if (arm && t_rise[g] >= 0.0) begin
                real w;
                w = $realtime - t_rise[g];
                chk((w > half_of(g) - 0.01) && (w < half_of(g) + 0.01), "R6",
                    $sformatf("high width ps out%0d", g),
                    int'(w * 1000.0), int'(half_of(g) * 1000.0));
                t_rise[g] = -1.0;
            end
        end
    end

    // scoreboard
    typedef struct {
        string        req;
        bit           pll;
        logic [N-1:0] act;
    } exp_t;

    exp_t sbq[$];
    bit   mon_busy = 0;

    task automatic expect_window(input string req, input bit pll, input logic [N-1:0] act);
        exp_t e;
        e.req = req; e.pll = pll; e.act = act;
        sbq.push_back(e);
        #1;
        while (sbq.size() != 0 || mon_busy) #1;
    endtask

    initial begin
        forever begin
            exp_t e;
            int   base [N];
            bit   p0;
            while (sbq.size() == 0) #1;
            mon_busy = 1;
            e = sbq.pop_front();
            for (int i = 0; i < N; i++) base[i] = rises[i];
            p0 = pll_off;
            #70;
            chk(p0 == e.pll && pll_off == e.pll, e.req, "pll_off over window",
                int'(pll_off), int'(e.pll));
            for (int i = 0; i < N; i++) begin
                chk(((rises[i] - base[i]) > 0) == e.act[i], e.req,
                    $sformatf("out%0d toggling", i),
                    int'((rises[i] - base[i]) > 0), int'(e.act[i]));
            end
            mon_busy = 0;
        end
    end

    task automatic cpu_edges(input int n);
        repeat (n) @(posedge c0);
        #1;
    endtask

    initial begin
        // R1 reset state
        cpu_edges(4);
        chk(pll_off == 1'b0, "R1", "pll_off in reset", int'(pll_off), 0);
        rst = 1'b0;
        arm = 1'b1;
        cpu_edges(1);
        chk(pll_off == 1'b0, "R1", "pll_off after reset", int'(pll_off), 0);
        expect_window("R1", 1'b0, 4'b1111);

        // R2 one-sample glitch is ignored
        cpu_edges(1);
        pwrdn_n = 1'b0;
        cpu_edges(1);
        pwrdn_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            chk(pll_off == 1'b0, "R2", "pll_off after glitch", int'(pll_off), 0);
            cpu_edges(1);
        end
        expect_window("R2", 1'b0, 4'b1111);

        // R3/R4 entry latency
        cpu_edges(1);
        pwrdn_n = 1'b0;
        cpu_edges(3);
        chk(pll_off == 1'b0, "R3", "pll_off after 3 edges", int'(pll_off), 0);
        cpu_edges(1);
        chk(pll_off == 1'b1, "R4", "pll_off after 4 edges", int'(pll_off), 1);
        expect_window("R5", 1'b1, 4'b0000);

        // enables rewritten while down: outputs stay low (R5)
        clk_en = 4'b1010;
        expect_window("R5", 1'b1, 4'b0000);

        // R9 release coincides with the new disables
        cpu_edges(1);
        pwrdn_n = 1'b1;
        cpu_edges(3);
        chk(pll_off == 1'b1, "R9", "pll_off after 3 edges", int'(pll_off), 1);
        cpu_edges(1);
        chk(pll_off == 1'b0, "R9", "pll_off after 4 edges", int'(pll_off), 0);
        expect_window("R9", 1'b0, 4'b1010);

        // R8 re-enable at an offset inside the CPU high phase
        @(posedge c0); #1.3;
        clk_en = 4'b1111;
        expect_window("R8", 1'b0, 4'b1111);

        // R7 static disable of two outputs
        @(posedge c0); #1.3;
        clk_en = 4'b0110;
        expect_window("R7", 1'b0, 4'b0110);

        // R5 power-down with a partial enable vector
        cpu_edges(1);
        pwrdn_n = 1'b0;
        cpu_edges(4);
        chk(pll_off == 1'b1, "R4", "pll_off second entry", int'(pll_off), 1);
        expect_window("R5", 1'b1, 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL all-requirements watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule